// File: doc/BRIEF.md
# Strobed Parallel Port with Service Request

This block is a byte-wide parallel port placed between a peripheral and a microprocessor bus. Eight data bits pass through a storage stage that is transparent while its latch clock is high and holds its contents once that clock drops. A two-pin device-select decode gates the port. A single mode pin decides two things: whether the latch is loaded by the strobe input or by the select term, and whether the output drivers are always on or are only on while the port is selected. The three-state pad is brought out as a data bus plus an output-enable flag.

A service-request flop raises an active-low interrupt after the peripheral strobes data in. When the processor selects the port to read that data, the select term clears the request. A low on the clear input empties the stored byte, unless the latch is transparent at that moment, and it also withdraws any pending request.

The design runs on one clock `clk_i`. The port inputs are sampled at its rising edge. The transparent data path, the output enable and the interrupt gating are combinational from the inputs, so no cycle is added to them. The reset `rst_ni` puts the block into its empty state with no request pending.

Top module: `strobe_port`

## Requirements
- R1: The port is selected exactly when `ds1_ni` is 0 and `ds2_i` is 1.
- R2: With `md_i`=1, `do_oe_o` is 1 whatever the other inputs are, and the latch clock is the select term.
- R3: With `md_i`=0, `do_oe_o` equals the select term, and the latch clock is `stb_i`.
- R4: While the latch clock is 1, `do_o` equals `di_i` in the same cycle.
- R5: While the latch clock is 0 and `clr_ni` is 1, `do_o` holds the value of `di_i` sampled at the last rising clock edge at which the latch clock was 1.
- R6: While `clr_ni` is 0 and the latch clock is 0, `do_o` is all zeros. The zero is still held after `clr_ni` returns to 1.
- R7: While `clr_ni` is 0 and the latch clock is 1, `do_o` keeps following `di_i`, because the latch clock overrides the clear.
- R8: If `stb_i` is sampled 1 at one rising edge and 0 at the next, the service request is set at that second edge. From then on, `int_no` is 0 while the port is not selected and `clr_ni` is 1.
- R9: `int_no` is 1 while the port is selected. Selection clears the request, so `int_no` stays 1 after the port is deselected until a new strobe falling edge occurs.
- R10: While `clr_ni` is 0, `int_no` is 1 and the request is cleared. After `rst_ni`, `do_o` is 0 and `int_no` is 1.
- R11: If a strobe falling edge and selection coincide at the same rising edge, the clear wins: no request is left pending afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| di_i | input | WIDTH | Data from the peripheral side |
| ds1_ni | input | 1 | Select input, active low |
| ds2_i | input | 1 | Select input, active high |
| md_i | input | 1 | Mode: 1 = output on, latch loaded by select; 0 = output gated by select, latch loaded by strobe |
| stb_i | input | 1 | Strobe; latch clock in mode 0, falling edge raises a request |
| clr_ni | input | 1 | Active-low clear of the stored byte and the request |
| do_o | output | WIDTH | Stored or transparent data toward the bus |
| do_oe_o | output | 1 | Output-driver enable; 0 stands for high impedance |
| int_no | output | 1 | Active-low interrupt |

## Verification
The main collision is a strobe falling edge and a processor select arriving at the same rising edge. One would set the request and the other would clear it. The bench drives the strobe high, then in the next cycle lowers it while it selects the port, then deselects the port. The interrupt must stay high, so the clear has won. A second collision is a clear asserted while the latch is transparent. The bench expects the input data to keep flowing through instead of zeros, and it expects the byte captured then to survive once the latch clock drops. Random mixes with rare selects and clears are compared cycle by cycle against a bench model.

// File: rtl/strobe_port_pkg.sv
`timescale 1ns/1ps
package strobe_port_pkg;
  typedef enum logic {
    MODE_STROBED = 1'b0,
    MODE_SELECT  = 1'b1
  } port_mode_e;

  typedef struct packed {
    logic sel;
    logic lclk;
    logic oe;
  } port_ctrl_t;
endpackage

// File: rtl/sp_select_ctrl.sv
`timescale 1ns/1ps
module sp_select_ctrl
  import strobe_port_pkg::*;
(
  input  logic       ds1_ni,
  input  logic       ds2_i,
  input  logic       md_i,
  input  logic       stb_i,
  output port_ctrl_t ctrl_o
);
  port_mode_e mode;
  logic       sel;

  assign mode = port_mode_e'(md_i);
  assign sel  = ~ds1_ni & ds2_i;

  always_comb begin
    ctrl_o.sel = sel;
    unique case (mode)
      MODE_SELECT: begin
        ctrl_o.lclk = sel;
        ctrl_o.oe   = 1'b1;
      end
      default: begin
        ctrl_o.lclk = stb_i;
        ctrl_o.oe   = sel;
      end
    endcase
  end
endmodule

// File: rtl/sp_data_latch.sv
`timescale 1ns/1ps
module sp_data_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lclk_i,
  input  logic             clr_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] hold_q;

  // per-bit: transparent while lclk high, clock beats clear
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign q_o[b] = lclk_i ? d_i[b] : (clr_ni & hold_q[b]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q[b] <= 1'b0;
      else         hold_q[b] <= q_o[b];
    end
  end
endmodule

// File: rtl/sp_service_req.sv
`timescale 1ns/1ps
module sp_service_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic sel_i,
  input  logic clr_ni,
  output logic int_no
);
  logic stb_q;
  logic req_q;
  logic stb_fall;
  logic req_clr;

  assign stb_fall = stb_q & ~stb_i;
  assign req_clr  = sel_i | ~clr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      stb_q <= stb_i;
      if (req_clr)       req_q <= 1'b0;  // clear dominates set
      else if (stb_fall) req_q <= 1'b1;
    end
  end

  // request masked at once by select or clear
  assign int_no = ~(req_q & ~req_clr);
endmodule

// File: rtl/strobe_port.sv
`timescale 1ns/1ps
module strobe_port
  import strobe_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] di_i,
  input  logic             ds1_ni,
  input  logic             ds2_i,
  input  logic             md_i,
  input  logic             stb_i,
  input  logic             clr_ni,
  output logic [WIDTH-1:0] do_o,
  output logic             do_oe_o,
  output logic             int_no
);
  port_ctrl_t ctrl;

  sp_select_ctrl u_ctrl (
    .ds1_ni (ds1_ni),
    .ds2_i  (ds2_i),
    .md_i   (md_i),
    .stb_i  (stb_i),
    .ctrl_o (ctrl)
  );

  sp_data_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lclk_i (ctrl.lclk),
    .clr_ni (clr_ni),
    .d_i    (di_i),
    .q_o    (do_o)
  );

  sp_service_req u_sreq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb_i),
    .sel_i  (ctrl.sel),
    .clr_ni (clr_ni),
    .int_no (int_no)
  );

  assign do_oe_o = ctrl.oe;
endmodule

// File: rtl/strobe_port_chk.sv
`timescale 1ns/1ps
module strobe_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] di_i,
  input logic             ds1_ni,
  input logic             ds2_i,
  input logic             md_i,
  input logic             stb_i,
  input logic             clr_ni,
  input logic [WIDTH-1:0] do_o,
  input logic             do_oe_o,
  input logic             int_no
);
  logic sel;
  logic lclk;
  logic armed_q;

  assign sel  = ~ds1_ni & ds2_i;
  assign lclk = md_i ? sel : stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_OE_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_i |-> do_oe_o); // R2
  AST_OE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !md_i |-> (do_oe_o == sel)); // R3
  AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lclk |-> (do_o == di_i)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !lclk && clr_ni && $past(!lclk && clr_ni)) |-> $stable(do_o)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !lclk) |-> (do_o == '0)); // R6
  AST_REQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $fell(stb_i) && !sel && clr_ni) |=> (!int_no || sel || !clr_ni)); // R8
  AST_SEL_NO_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |-> int_no); // R9
  AST_CLR_NO_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> int_no); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $fell(stb_i) && sel) |=> int_no); // R11
endmodule

bind strobe_port strobe_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .di_i    (di_i),
  .ds1_ni  (ds1_ni),
  .ds2_i   (ds2_i),
  .md_i    (md_i),
  .stb_i   (stb_i),
  .clr_ni  (clr_ni),
  .do_o    (do_o),
  .do_oe_o (do_oe_o),
  .int_no  (int_no)
);

// File: tb/strobe_port_tb_top.sv
`timescale 1ns/1ps
module strobe_port_tb_top;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] di_i = '0;
  logic         ds1_ni = 1'b1;
  logic         ds2_i = 1'b0;
  logic         md_i = 1'b0;
  logic         stb_i = 1'b0;
  logic         clr_ni = 1'b1;
  logic [W-1:0] do_o;
  logic         do_oe_o;
  logic         int_no;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [W-1:0] m_q = '0;
  logic         m_req = 1'b0;
  logic         m_stb = 1'b0;

  always #2.5 clk_i = ~clk_i;

  strobe_port #(.WIDTH(W)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .di_i (di_i),
    .ds1_ni (ds1_ni), .ds2_i (ds2_i), .md_i (md_i),
    .stb_i (stb_i), .clr_ni (clr_ni),
    .do_o (do_o), .do_oe_o (do_oe_o), .int_no (int_no)
  );

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic f_sel(logic ds1n, logic ds2);
    return ~ds1n & ds2;
  endfunction

  function automatic logic f_lclk(logic md, logic sel, logic stb);
    return md ? sel : stb;
  endfunction

  function automatic logic [W-1:0] f_data(logic lc, logic clrn, logic [W-1:0] di, logic [W-1:0] q);
    return lc ? di : (clrn ? q : '0);
  endfunction

  // one cycle: drive at negedge, check mid-low phase, update model at posedge
  task automatic step(string tag, logic [W-1:0] di, logic ds1n, logic ds2,
                      logic md, logic stb, logic clrn);
    logic sel, lc, e_oe, e_int;
    logic [W-1:0] e_do;
    @(negedge clk_i);
    di_i = di; ds1_ni = ds1n; ds2_i = ds2; md_i = md; stb_i = stb; clr_ni = clrn;
    #1;
    sel   = f_sel(ds1n, ds2);
    lc    = f_lclk(md, sel, stb);
    e_oe  = md | sel;
    e_do  = f_data(lc, clrn, di, m_q);
    e_int = ~(m_req & ~sel & clrn);
    check(tag, "do_oe_o", {31'b0, do_oe_o}, {31'b0, e_oe});
    check(tag, "do_o", {24'b0, do_o}, {24'b0, e_do});
    check(tag, "int_no", {31'b0, int_no}, {31'b0, e_int});
    @(posedge clk_i);
    m_q = e_do;
    if (sel || !clrn)      m_req = 1'b0;
    else if (m_stb && !stb) m_req = 1'b1;
    m_stb = stb;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0011));
    // R10 reset state
    #12;
    check("R10", "reset do_o", {24'b0, do_o}, 32'h0);
    check("R10", "reset int_no", {31'b0, int_no}, 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 decode: all ds combinations in mode 0
    for (int k = 0; k < 4; k++)
      step("R1", 8'h3c, k[0], k[1], 1'b0, 1'b0, 1'b1);

    // R2 R3 full stb/md/select table
    for (int k = 0; k < 8; k++) begin
      logic s, m, b;
      {s, m, b} = k[2:0];
      step(m ? "R2" : "R3", 8'(8'h11 * (k + 1)), ~s, s, m, b, 1'b1);
      step(m ? "R2" : "R3", 8'ha5, 1'b1, 1'b0, m, 1'b0, 1'b1);
    end

    // R4 R5 strobed load then hold
    step("R4", 8'h5a, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R5", 8'hff, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5", "held byte", {24'b0, do_o}, 32'h5a);
    step("R5", 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R10", 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R6 clear while opaque, zero persists
    step("R6", 8'h77, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6", "cleared", {24'b0, do_o}, 32'h0);
    step("R6", 8'h77, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R6", "stays cleared", {24'b0, do_o}, 32'h0);

    // R7 clear while transparent
    step("R7", 8'hc3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7", "flow-through", {24'b0, do_o}, 32'hc3);
    step("R7", 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R7", "captured", {24'b0, do_o}, 32'hc3);

    // R8 R9 interrupt set and acknowledge
    step("R8", 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R8", 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R8", 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R8", "pending", {31'b0, int_no}, 32'h0);
    step("R9", 8'h04, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R9", 8'h05, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9", "acknowledged", {31'b0, int_no}, 32'h1);

    // R10 clear withdraws request
    step("R10", 8'h06, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R10", 8'h07, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R10", 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R10", 8'h09, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10", "withdrawn", {31'b0, int_no}, 32'h1);

    // R11 strobe fall coincides with select
    step("R11", 8'h0a, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R11", 8'h0b, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R11", 8'h0c, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R11", "clear wins", {31'b0, int_no}, 32'h1);

    // random mix: rare select and clear
    for (int n = 0; n < 3000; n++) begin
      logic sel_r, clr_r;
      sel_r = ($urandom_range(0, 5) == 0);
      clr_r = ($urandom_range(0, 9) != 0);
      step("R4 R5 R8 R9", 8'($urandom), ~sel_r | ($urandom_range(0, 1) == 0 && !sel_r),
           sel_r, 1'($urandom), 1'($urandom), clr_r);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule